// File: doc/BRIEF.md
# Post-Modify Address Generation Unit

This block forms the memory address for each load and, where the addressing mode calls for it, the pointer value that goes back to the register file. A three-bit mode code selects one of eight ways of forming the address. Two modes only compute an address. One loads an absolute constant and also writes it to the pointer. The other five read at the current pointer and then move it: by a modifier register, by an immediate, through a bit-reversed view of the low address bits, or around a circular buffer.

The effective address is combinational and is valid in the same cycle as the inputs. The updated pointer and its write enable are registered and appear one clock edge after an accepted operation. The immediate increment arrives already scaled by the access size. In the circular register mode the block scales the packed increment itself. Both the length and the increment of that mode live in the modifier register. Any byte or halfword load can use any mode.

Top module: `pmagu_top`

## Requirements
- R1: While reset is asserted and after it is released, before any operation is accepted, `wb_en` is 0 and `wb_ptr` is 0.
- R2: Mode 0 (base plus offset): `ea_out` = `ptr_in` + `imm_in`, with the immediate taken as signed. The next cycle shows `wb_en` = 0.
- R3: Mode 1 (scaled index): `ea_out` = (`idx_in` << `shamt`) + `imm_in`. The next cycle shows `wb_en` = 0.
- R4: Mode 2 (absolute): `ea_out` = `imm_in`. The next cycle shows `wb_en` = 1 and `wb_ptr` = that same constant.
- R5: Mode 3 (post-modify by register): `ea_out` = `ptr_in`. The next cycle shows `wb_en` = 1 and `wb_ptr` = `ptr_in` + `mod_in`.
- R6: Mode 4 (bit-reversed): `ea_out` keeps `ptr_in[31:16]` and holds the reverse of `ptr_in[15:0]` in its low half, so bit i maps to bit 15-i. The pointer is written back as `ptr_in` + `mod_in` with no reversal. From a 64 KiB-aligned pointer with a modifier of 0x2000, the low address halves of successive accesses are 0, 4, 2 and 6.
- R7: Mode 5 (post-increment by immediate): `ea_out` = `ptr_in`. The next cycle shows `wb_en` = 1 and `wb_ptr` = `ptr_in` + `imm_in` (signed).
- R8: Mode 6 (circular by immediate): `ea_out` = `ptr_in`. The buffer spans `cstart_in` up to but not including `cstart_in` + `mod_in[16:0]`. The written pointer is `ptr_in` + `imm_in`, brought back into that span.
- R9: Mode 7 (circular by register): the increment is the signed 7-bit value `mod_in[23:17]`. It is multiplied by 1 when `acc_half` = 0 (byte) and by 2 when `acc_half` = 1 (halfword). Length and wrap are as in R8.
- R10: Circular wrap works in both directions. A sum at or above start + length has the length subtracted, and a sum below start has the length added.
- R11: When `op_valid` = 0, the next cycle shows `wb_en` = 0 and `wb_ptr` unchanged. Operations in modes 0 and 1 also leave `wb_ptr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| op_valid | input | 1 | Operation present this cycle |
| op_mode | input | 3 | Addressing mode, codes 0..7 as in R2..R9 |
| acc_half | input | 1 | Access size: 0 byte, 1 halfword |
| ptr_in | input | 32 | Pointer or base register value |
| idx_in | input | 32 | Index register value |
| imm_in | input | 32 | Offset, absolute constant or pre-scaled increment |
| shamt | input | 5 | Index shift amount |
| mod_in | input | 32 | Modifier register |
| cstart_in | input | 32 | Circular buffer start address |
| ea_out | output | 32 | Effective address, combinational |
| wb_ptr | output | 32 | Registered updated pointer |
| wb_en | output | 1 | Registered pointer write enable |

## Verification
Each post-modify mode is run as a chain of four accesses, with each written-back pointer fed in as the next pointer. This shows whether the update is applied once per access and whether the address uses the old pointer or the new one. The circular modes are run with a length of two and one byte step, a length of four and a halfword step, and negative increments starting from the buffer start. Together these exercise the upper wrap, the lower wrap and the case with no wrap. The bit-reversed mode is run from an aligned pointer and from one with non-zero upper bits, which shows that only the low sixteen bits are mirrored. Idle cycles and operations in modes 0 and 1 placed between write-backs check that the pointer output holds.

// File: rtl/pmagu_pkg.sv
package pmagu_pkg;

  typedef enum logic [2:0] {
    AM_BASE_OFF = 3'd0,
    AM_SCALED   = 3'd1,
    AM_ABS      = 3'd2,
    AM_POST_MOD = 3'd3,
    AM_BITREV   = 3'd4,
    AM_POST_IMM = 3'd5,
    AM_CIRC_IMM = 3'd6,
    AM_CIRC_REG = 3'd7
  } am_mode_e;

  // Modes that produce a pointer write-back.
  function automatic logic am_writes(am_mode_e m);
    return (m != AM_BASE_OFF) && (m != AM_SCALED);
  endfunction

endpackage

// File: rtl/pmagu_bitrev.sv
module pmagu_bitrev #(
  parameter int AW = 32,
  parameter int RB = 16
) (
  input  logic [AW-1:0] a,
  output logic [AW-1:0] y
);

  // Mirror the low RB bits; upper bits pass straight through.
  for (genvar i = 0; i < RB; i++) begin : g_rev
    assign y[i] = a[RB-1-i];
  end
  assign y[AW-1:RB] = a[AW-1:RB];

endmodule

// File: rtl/pmagu_circ.sv
module pmagu_circ #(
  parameter int AW = 32,
  parameter int LW = 17
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] start,
  input  logic [LW-1:0] len,
  output logic [AW-1:0] nxt
);

  logic [AW-1:0] raw;
  logic [AW-1:0] len_x;
  logic [AW-1:0] lim;

  // One add, one compare pair, one correction: valid while |step| <= len.
  always_comb begin
    len_x = {{(AW-LW){1'b0}}, len};
    raw   = cur + step;
    lim   = start + len_x;
    if (raw >= lim) begin
      nxt = raw - len_x;
    end else if (raw < start) begin
      nxt = raw + len_x;
    end else begin
      nxt = raw;
    end
  end

endmodule

// File: rtl/pmagu_top.sv
module pmagu_top
  import pmagu_pkg::*;
#(
  parameter int AW   = 32,
  parameter int SHW  = 5,
  parameter int RB   = 16,
  parameter int LW   = 17,
  parameter int CW   = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [2:0]     op_mode,
  input  logic           acc_half,
  input  logic [AW-1:0]  ptr_in,
  input  logic [AW-1:0]  idx_in,
  input  logic [AW-1:0]  imm_in,
  input  logic [SHW-1:0] shamt,
  input  logic [AW-1:0]  mod_in,
  input  logic [AW-1:0]  cstart_in,
  output logic [AW-1:0]  ea_out,
  output logic [AW-1:0]  wb_ptr,
  output logic           wb_en
);

  localparam int CI_LO = LW;
  localparam int CI_HI = LW + CW - 1;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  am_mode_e mode;
  assign mode = am_mode_e'(op_mode);

  // Bit-reversed view of the pointer.
  logic [AW-1:0] ptr_rev;
  pmagu_bitrev #(.AW(AW), .RB(RB)) u_rev (
    .a (ptr_in),
    .y (ptr_rev)
  );

  // Circular step: immediate, or packed signed count scaled by access size.
  logic [AW-1:0] reg_cnt;
  logic [AW-1:0] reg_step;
  logic [AW-1:0] circ_step;
  logic [AW-1:0] circ_nxt;

  assign reg_cnt   = {{(AW-CW){mod_in[CI_HI]}}, mod_in[CI_HI:CI_LO]};
  assign reg_step  = acc_half ? (reg_cnt << 1) : reg_cnt;
  assign circ_step = (mode == AM_CIRC_REG) ? reg_step : imm_in;

  pmagu_circ #(.AW(AW), .LW(LW)) u_circ (
    .cur   (ptr_in),
    .step  (circ_step),
    .start (cstart_in),
    .len   (mod_in[LW-1:0]),
    .nxt   (circ_nxt)
  );

  // Next-state logic.
  logic [AW-1:0] ea_d;
  logic [AW-1:0] nptr_d;
  logic          wr_d;
  logic          ptr_ce;

  always_comb begin
    ea_d   = ptr_in;
    nptr_d = ptr_in;
    unique case (mode)
      AM_BASE_OFF: ea_d = ptr_in + imm_in;
      AM_SCALED:   ea_d = (idx_in << shamt) + imm_in;
      AM_ABS: begin
        ea_d   = imm_in;
        nptr_d = imm_in;
      end
      AM_POST_MOD: nptr_d = ptr_in + mod_in;
      AM_BITREV: begin
        ea_d   = ptr_rev;
        nptr_d = ptr_in + mod_in;
      end
      AM_POST_IMM: nptr_d = ptr_in + imm_in;
      AM_CIRC_IMM,
      AM_CIRC_REG: nptr_d = circ_nxt;
      default: ;
    endcase
    wr_d   = op_valid && am_writes(mode);
    ptr_ce = wr_d;
  end

  assign ea_out = ea_d;

  // Registers.
  logic [AW-1:0] wb_ptr_q;
  logic          wb_en_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wb_en_q  <= 1'b0;
      wb_ptr_q <= '0;
    end else begin
      wb_en_q <= wr_d;
      if (ptr_ce) begin
        wb_ptr_q <= nptr_d;
      end
    end
  end

  assign wb_ptr = wb_ptr_q;
  assign wb_en  = wb_en_q;

endmodule

// File: rtl/pmagu_chk.sv
module pmagu_chk #(
  parameter int AW = 32,
  parameter int LW = 17
) (
  input logic          clk,
  input logic          rst_ok,
  input logic          op_valid,
  input logic [2:0]    op_mode,
  input logic [AW-1:0] ptr_in,
  input logic [AW-1:0] imm_in,
  input logic [AW-1:0] mod_in,
  input logic [AW-1:0] cstart_in,
  input logic [AW-1:0] ea_out,
  input logic [AW-1:0] wb_ptr,
  input logic          wb_en
);

  logic [AW-1:0] len_x;
  logic          circ_safe;

  assign len_x = {{(AW-LW){1'b0}}, mod_in[LW-1:0]};
  assign circ_safe = op_valid && (op_mode == 3'd6) && (len_x != '0) &&
                     (ptr_in >= cstart_in) && (ptr_in < cstart_in + len_x) &&
                     ($signed(imm_in) <= $signed(len_x)) &&
                     ($signed(imm_in) >= -$signed(len_x));

  a_r2_base_no_wb: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && op_mode == 3'd0) |=> !wb_en);

  a_r4_abs_writes_const: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && op_mode == 3'd2) |=> (wb_en && wb_ptr == $past(imm_in)));

  a_r5_post_uses_old_ptr: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_mode == 3'd3) |-> (ea_out == ptr_in));

  a_r6_rev_keeps_upper: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_mode == 3'd4) |-> (ea_out[AW-1:16] == ptr_in[AW-1:16]));

  a_r8_circ_in_window: assert property (@(posedge clk) disable iff (!rst_ok)
    circ_safe |=> (wb_ptr >= $past(cstart_in) &&
                   wb_ptr < $past(cstart_in) + $past(len_x)));

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_ok)
    !op_valid |=> (!wb_en && $stable(wb_ptr)));

endmodule

bind pmagu_top pmagu_chk #(.AW(AW), .LW(LW)) chk_i (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .op_valid  (op_valid),
  .op_mode   (op_mode),
  .ptr_in    (ptr_in),
  .imm_in    (imm_in),
  .mod_in    (mod_in),
  .cstart_in (cstart_in),
  .ea_out    (ea_out),
  .wb_ptr    (wb_ptr),
  .wb_en     (wb_en)
);

// File: tb/pmagu_top_tb_top.sv
module pmagu_top_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [2:0]  op_mode;
  logic        acc_half;
  logic [31:0] ptr_in, idx_in, imm_in, mod_in, cstart_in;
  logic [4:0]  shamt;
  logic [31:0] ea_out, wb_ptr;
  logic        wb_en;

  int total = 0;
  int bad   = 0;

  logic [31:0] exp_ptr;
  logic        exp_en;

  pmagu_top dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_mode(op_mode),
    .acc_half(acc_half), .ptr_in(ptr_in), .idx_in(idx_in), .imm_in(imm_in),
    .shamt(shamt), .mod_in(mod_in), .cstart_in(cstart_in),
    .ea_out(ea_out), .wb_ptr(wb_ptr), .wb_en(wb_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, string what, longint act, longint expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, expv);
    end
  endtask

  // Behavioural reference.
  function automatic logic [31:0] ref_ea(int m, logic [31:0] p, logic [31:0] ix,
                                         logic [31:0] im, int sh);
    logic [31:0] r;
    case (m)
      0: return p + im;
      1: return (ix << sh) + im;
      2: return im;
      4: begin
        r = p;
        for (int b = 0; b < 16; b++) r[b] = p[15-b];
        return r;
      end
      default: return p;
    endcase
  endfunction

  function automatic logic [31:0] ref_nxt(int m, logic hf, logic [31:0] p,
                                          logic [31:0] im, logic [31:0] md,
                                          logic [31:0] cs);
    longint t, len, inc, cnt;
    case (m)
      2: return im;
      3, 4: return p + md;
      5: return p + im;
      6, 7: begin
        len = longint'(md & 32'h1ffff);
        if (m == 6) inc = longint'($signed(im));
        else begin
          cnt = longint'((md >> 17) & 32'h7f);
          if (cnt >= 64) cnt = cnt - 128;
          inc = hf ? cnt * 2 : cnt;
        end
        t = longint'(p) + inc;
        if (t >= longint'(cs) + len) t = t - len;
        else if (t < longint'(cs)) t = t + len;
        return t[31:0];
      end
      default: return p;
    endcase
  endfunction

  // One operation per clock; called right after a falling edge.
  task automatic step(string tag, logic v, int m, logic hf, logic [31:0] p,
                      logic [31:0] ix, logic [31:0] im, int sh,
                      logic [31:0] md, logic [31:0] cs);
    logic [31:0] e_ea, e_n;
    logic        wr;
    op_valid = v; op_mode = 3'(m); acc_half = hf; ptr_in = p; idx_in = ix;
    imm_in = im; shamt = 5'(sh); mod_in = md; cstart_in = cs;
    #1;
    e_ea = ref_ea(m, p, ix, im, sh);
    e_n  = ref_nxt(m, hf, p, im, md, cs);
    wr   = v && (m >= 2);
    if (v) chk(tag, "ea_out", ea_out, e_ea);
    @(posedge clk);
    exp_en = wr;
    if (wr) exp_ptr = e_n;
    @(negedge clk);
    chk(tag, "wb_en", wb_en, exp_en);
    chk(tag, "wb_ptr", wb_ptr, exp_ptr);
  endtask

  task automatic idle(string tag);
    step(tag, 1'b0, 0, 1'b0, 32'h0, 32'h0, 32'h0, 0, 32'h0, 32'h0);
  endtask

  localparam logic [31:0] BUF = 32'h0001_0000;

  initial begin : wd
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0; op_valid = 1'b0; op_mode = 3'd0; acc_half = 1'b0;
    ptr_in = '0; idx_in = '0; imm_in = '0; shamt = '0; mod_in = '0; cstart_in = '0;
    exp_ptr = '0; exp_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "wb_en in reset", wb_en, 0);
    chk("R1", "wb_ptr in reset", wb_ptr, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "wb_en after release", wb_en, 0);
    chk("R1", "wb_ptr after release", wb_ptr, 0);

    // R4 first so the pointer output is non-zero for later hold checks
    for (int k = 0; k < 4; k++)
      step("R4", 1'b1, 2, 1'b0, 32'h0, 32'h0, BUF + 32'(k), 0, 32'h0, 32'h0);

    // R2: base plus offset, incl. negative offset; pointer must hold (R11)
    for (int k = 0; k < 4; k++)
      step("R2", 1'b1, 0, 1'b0, BUF, 32'h0, 32'(k*2), 0, 32'h0, 32'h0);
    step("R2", 1'b1, 0, 1'b0, BUF, 32'h0, 32'hffff_fffc, 0, 32'h0, 32'h0);
    chk("R11", "ptr held after base mode", wb_ptr, BUF + 3);

    // R3: scaled index
    for (int k = 0; k < 4; k++)
      step("R3", 1'b1, 1, 1'b0, 32'h0, 32'(k), BUF, 1, 32'h0, 32'h0);
    step("R3", 1'b1, 1, 1'b0, 32'h0, 32'h3, BUF, 4, 32'h0, 32'h0);

    // R11: idle cycles
    idle("R11");
    idle("R11");
    chk("R11", "ptr held while idle", wb_ptr, BUF + 3);

    // R5: post-modify by register, byte and halfword chains
    exp_ptr = BUF;
    step("R5", 1'b1, 2, 1'b0, 32'h0, 32'h0, BUF, 0, 32'h0, 32'h0);
    for (int k = 0; k < 4; k++)
      step("R5", 1'b1, 3, 1'b0, exp_ptr, 32'h0, 32'h0, 0, 32'h1, 32'h0);
    chk("R5", "chain end", wb_ptr, BUF + 4);
    for (int k = 0; k < 4; k++)
      step("R5", 1'b1, 3, 1'b1, exp_ptr, 32'h0, 32'h0, 0, 32'h2, 32'h0);

    // R6: bit-reversed from aligned pointer, offsets 0,4,2,6
    step("R6", 1'b1, 2, 1'b0, 32'h0, 32'h0, BUF, 0, 32'h0, 32'h0);
    for (int k = 0; k < 4; k++) begin
      int offs [4] = '{0, 4, 2, 6};
      op_valid = 1'b1; op_mode = 3'd4; ptr_in = exp_ptr; #1;
      chk("R6", "reversed low offset", ea_out - BUF, offs[k]);
      step("R6", 1'b1, 4, 1'b0, exp_ptr, 32'h0, 32'h0, 0, 32'h2000, 32'h0);
    end
    step("R6", 1'b1, 4, 1'b0, 32'hABCD_0001, 32'h0, 32'h0, 0, 32'h10, 32'h0);
    step("R6", 1'b1, 4, 1'b0, 32'h1234_00F0, 32'h0, 32'h0, 0, 32'h0, 32'h0);

    // R7: post-increment by immediate, positive then negative
    for (int k = 0; k < 4; k++)
      step("R7", 1'b1, 5, 1'b1, exp_ptr, 32'h0, 32'h2, 0, 32'h0, 32'h0);
    step("R7", 1'b1, 5, 1'b0, exp_ptr, 32'h0, 32'hffff_ffff, 0, 32'h0, 32'h0);

    // R8: circular immediate, length 2 step 1, then length 4 step 2
    step("R8", 1'b1, 2, 1'b0, 32'h0, 32'h0, BUF, 0, 32'h0, 32'h0);
    for (int k = 0; k < 4; k++)
      step("R8", 1'b1, 6, 1'b0, exp_ptr, 32'h0, 32'h1, 0, 32'h2, BUF);
    chk("R8", "wrapped to start", wb_ptr, BUF);
    for (int k = 0; k < 4; k++)
      step("R8", 1'b1, 6, 1'b1, exp_ptr, 32'h0, 32'h2, 0, 32'h4, BUF);

    // R9: circular register, byte and halfword, then negative count
    for (int k = 0; k < 4; k++)
      step("R9", 1'b1, 7, 1'b0, exp_ptr, 32'h0, 32'h0, 0, (32'h1 << 17) | 32'h2, BUF);
    for (int k = 0; k < 4; k++)
      step("R9", 1'b1, 7, 1'b1, exp_ptr, 32'h0, 32'h0, 0, (32'h1 << 17) | 32'h4, BUF);
    step("R9", 1'b1, 7, 1'b1, BUF, 32'h0, 32'h0, 0, (32'h7f << 17) | 32'h8, BUF);
    chk("R9", "negative halfword count wraps", wb_ptr, BUF + 6);

    // R10: negative immediate from the start wraps upward, then downward
    step("R10", 1'b1, 6, 1'b0, 32'h2000, 32'h0, 32'hffff_fffe, 0, 32'h8, 32'h2000);
    chk("R10", "lower wrap", wb_ptr, 32'h2006);
    step("R10", 1'b1, 6, 1'b0, exp_ptr, 32'h0, 32'h3, 0, 32'h8, 32'h2000);
    chk("R10", "upper wrap", wb_ptr, 32'h2001);
    step("R10", 1'b1, 6, 1'b0, exp_ptr, 32'h0, 32'h2, 0, 32'h8, 32'h2000);

    idle("R11");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule